// File: doc/BRIEF.md
# Clock-Reference Capture Counter

This block keeps a free-running 42-bit count of the local master clock, which comes from an external voltage-controlled oscillator. A packet parser upstream pulses a capture strobe when it pulls a clock-reference field out of a transport packet. On that pulse the block copies the running count into a latch register. Software reads the latched count and compares it with the received reference to steer a frequency-lock loop.

The host reaches the block through a small synchronous register port. The count is seen as three 16-bit words: low, middle and high. The high word carries 10 bits and reads zero above them. Writing the middle or high word presets that slice and halts counting. Writing the low word presets only that slice. A write to a dedicated resume address restarts counting.

A select bit in the control register picks where count reads come from. When it is clear, reads return the latched count. When it is set, reads return the live count. The live count is snapshotted on the low-word read, so the three words always belong to one instant. The select bit clears itself once the high word has been read. Each capture sets a pending flag that drives an interrupt when unmasked. A capture that lands while the flag is still pending sets an overrun flag.

Top module: `clkref_capture_counter`

## Requirements
- R1: After reset the count is 0 and running. While running and not loaded, it rises by one on every clock edge, wrapping from 2^42-1 to 0.
- R2: On a clock edge with `cap_stb` high, the latch register takes the count value held before that edge.
- R3: Count words map as follows. Address 0 holds bits 15:0, address 1 holds bits 31:16 and address 2 holds bits 41:32 in data bits 9:0. Data bits 15:10 of address 2 read as 0.
- R4: A write to address 1 or 2 loads that slice and stops the count. A write to address 0 loads bits 15:0 and leaves the run state unchanged.
- R5: A write of any data to address 3 restarts counting from the held value.
- R6: Address 4 is control: bit 15 is the live-read select and bit 0 is the interrupt enable. With select at 0, reads of addresses 0 to 2 return the latched count.
- R7: With select at 1, a read of address 0 returns the live low word and snapshots all 42 bits. Reads of addresses 1 and 2 return that snapshot. A read of address 2 then clears select to 0.
- R8: A capture sets pending (address 5 bit 0), and `irq` equals pending AND enable. Writing 1 to bit 0 of address 5 clears pending. A capture in the same cycle as that write leaves pending set.
- R9: A capture while pending is already 1 sets overrun (address 5 bit 1) and still overwrites the latch. Writing 1 to bit 1 of address 5 clears overrun.
- R10: After reset the control register, status, latch and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_stb | input | 1 | One-cycle pulse: clock reference extracted |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (one cycle per read) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the addressed register, combinational |
| irq | output | 1 | Interrupt request to the host |

## Verification
A miscounting or stalled counter shows up at the ports as soon as a live read is taken, a fixed number of cycles after a preset. The bench uses those exact distances, so an off-by-one in the run or load path is caught within a few cycles. A latch or snapshot that takes the wrong instant appears on the very next word read: the middle word is read after the low word has rolled over, so a torn snapshot returns the wrong middle value. A stuck select, pending or overrun bit shows on the next control or status read, or directly on `irq` one cycle after the causing event.

// File: rtl/clkref_pkg.sv
`timescale 1ns/1ps
package clkref_pkg;

  localparam int unsigned WORD_W = 16;

  typedef enum logic [2:0] {
    RA_LO     = 3'd0,
    RA_MID    = 3'd1,
    RA_HI     = 3'd2,
    RA_RESUME = 3'd3,
    RA_CTRL   = 3'd4,
    RA_STAT   = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    SL_LO  = 2'd0,
    SL_MID = 2'd1,
    SL_HI  = 2'd2
  } slice_e;

  localparam int unsigned CTRL_SEL_BIT = 15;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned STAT_PND_BIT = 0;
  localparam int unsigned STAT_OVR_BIT = 1;

  // Pick one 16-bit word of a count held in a 64-bit container.
  function automatic logic [WORD_W-1:0] slice_get(logic [63:0] v, slice_e s);
    logic [WORD_W-1:0] r;
    case (s)
      SL_LO:   r = v[15:0];
      SL_MID:  r = v[31:16];
      default: r = v[47:32];
    endcase
    return r;
  endfunction

  // Replace one 16-bit word of a count held in a 64-bit container.
  function automatic logic [63:0] slice_put(logic [63:0] v, slice_e s,
                                           logic [WORD_W-1:0] w);
    logic [63:0] r;
    r = v;
    case (s)
      SL_LO:   r[15:0]  = w;
      SL_MID:  r[31:16] = w;
      default: r[47:32] = w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clkref_counter.sv
`timescale 1ns/1ps
module clkref_counter
  import clkref_pkg::*;
#(
  parameter int unsigned CNT_W = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  slice_e            load_sel,
  input  logic [WORD_W-1:0] load_data,
  input  logic              stop_req,
  input  logic              resume_req,
  output logic [CNT_W-1:0]  count,
  output logic              running
);

  logic [63:0] count_wide;
  logic        inc_evt;

  assign count_wide = 64'(count);
  assign inc_evt    = running && !load_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b1;
    end else begin
      if (load_en) begin
        count <= CNT_W'(slice_put(count_wide, load_sel, load_data));
      end else if (running) begin
        count <= count + CNT_W'(1);
      end
      if (stop_req) begin
        running <= 1'b0;
      end else if (resume_req) begin
        running <= 1'b1;
      end
    end
  end

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> count == CNT_W'($past(count) + CNT_W'(1)));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load_en) |=> $stable(count));

  // R4
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !running);

  // R5
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_req && !stop_req) |=> running);

endmodule

// File: rtl/clkref_capture.sv
`timescale 1ns/1ps
module clkref_capture #(
  parameter int unsigned CNT_W = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_stb,
  input  logic [CNT_W-1:0] count,
  input  logic             clr_pend,
  input  logic             clr_ovr,
  output logic [CNT_W-1:0] latch,
  output logic             pending,
  output logic             overrun
);

  logic set_ovr_evt;

  assign set_ovr_evt = cap_stb && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch   <= '0;
      pending <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (cap_stb) begin
        latch <= count;
      end
      if (cap_stb) begin
        pending <= 1'b1;
      end else if (clr_pend) begin
        pending <= 1'b0;
      end
      if (set_ovr_evt) begin
        overrun <= 1'b1;
      end else if (clr_ovr) begin
        overrun <= 1'b0;
      end
    end
  end

  // R2
  latch_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> latch == $past(count));

  // R2
  latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> $stable(latch));

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> pending);

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovr_evt |=> overrun);

endmodule

// File: rtl/clkref_host_regs.sv
`timescale 1ns/1ps
module clkref_host_regs
  import clkref_pkg::*;
#(
  parameter int unsigned CNT_W  = 42,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  latch,
  input  logic              pending,
  input  logic              overrun,
  output logic [WORD_W-1:0] host_rdata,
  output logic              irq,
  output logic              load_en,
  output slice_e            load_sel,
  output logic [WORD_W-1:0] load_data,
  output logic              stop_req,
  output logic              resume_req,
  output logic              clr_pend,
  output logic              clr_ovr
);

  logic sel_lo, sel_mid, sel_hi, sel_res, sel_ctrl, sel_stat;
  logic wr_lo, wr_mid, wr_hi, wr_ctrl, wr_stat;
  logic rd_lo_live, rd_hi_live;
  logic live_sel, irq_en;
  logic [CNT_W-1:0] shadow;
  logic [63:0] live_wide, shadow_wide, latch_wide;

  assign sel_lo   = host_addr == ADDR_W'(RA_LO);
  assign sel_mid  = host_addr == ADDR_W'(RA_MID);
  assign sel_hi   = host_addr == ADDR_W'(RA_HI);
  assign sel_res  = host_addr == ADDR_W'(RA_RESUME);
  assign sel_ctrl = host_addr == ADDR_W'(RA_CTRL);
  assign sel_stat = host_addr == ADDR_W'(RA_STAT);

  assign wr_lo   = host_wr && sel_lo;
  assign wr_mid  = host_wr && sel_mid;
  assign wr_hi   = host_wr && sel_hi;
  assign wr_ctrl = host_wr && sel_ctrl;
  assign wr_stat = host_wr && sel_stat;

  assign rd_lo_live = host_rd && sel_lo && live_sel;
  assign rd_hi_live = host_rd && sel_hi && live_sel;

  assign load_en    = wr_lo || wr_mid || wr_hi;
  assign load_sel   = wr_hi ? SL_HI : (wr_mid ? SL_MID : SL_LO);
  assign load_data  = host_wdata;
  assign stop_req   = wr_mid || wr_hi;
  assign resume_req = host_wr && sel_res;
  assign clr_pend   = wr_stat && host_wdata[STAT_PND_BIT];
  assign clr_ovr    = wr_stat && host_wdata[STAT_OVR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_sel <= 1'b0;
      irq_en   <= 1'b0;
      shadow   <= '0;
    end else begin
      if (wr_ctrl) begin
        live_sel <= host_wdata[CTRL_SEL_BIT];
        irq_en   <= host_wdata[CTRL_EN_BIT];
      end else if (rd_hi_live) begin
        live_sel <= 1'b0;
      end
      if (rd_lo_live) begin
        shadow <= count;
      end
    end
  end

  assign live_wide   = 64'(count);
  assign shadow_wide = 64'(shadow);
  assign latch_wide  = 64'(latch);

  always_comb begin
    host_rdata = '0;
    if (sel_lo) begin
      host_rdata = slice_get(live_sel ? live_wide : latch_wide, SL_LO);
    end else if (sel_mid) begin
      host_rdata = slice_get(live_sel ? shadow_wide : latch_wide, SL_MID);
    end else if (sel_hi) begin
      host_rdata = slice_get(live_sel ? shadow_wide : latch_wide, SL_HI);
    end else if (sel_ctrl) begin
      host_rdata[CTRL_SEL_BIT] = live_sel;
      host_rdata[CTRL_EN_BIT]  = irq_en;
    end else if (sel_stat) begin
      host_rdata[STAT_PND_BIT] = pending;
      host_rdata[STAT_OVR_BIT] = overrun;
    end
  end

  assign irq = pending && irq_en;

  // R7
  sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi_live && !wr_ctrl) |=> !live_sel);

  // R7
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_live |=> shadow == $past(count));

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !host_wdata[CTRL_EN_BIT]) |=> !irq);

endmodule

// File: rtl/clkref_capture_counter.sv
`timescale 1ns/1ps
module clkref_capture_counter
  import clkref_pkg::*;
#(
  parameter int unsigned CNT_W  = 42,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_stb,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              irq
);

  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  latch;
  logic              running;
  logic              pending;
  logic              overrun;
  logic              load_en;
  slice_e            load_sel;
  logic [WORD_W-1:0] load_data;
  logic              stop_req;
  logic              resume_req;
  logic              clr_pend;
  logic              clr_ovr;

  clkref_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_sel   (load_sel),
    .load_data  (load_data),
    .stop_req   (stop_req),
    .resume_req (resume_req),
    .count      (count),
    .running    (running)
  );

  clkref_capture #(.CNT_W(CNT_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_stb  (cap_stb),
    .count    (count),
    .clr_pend (clr_pend),
    .clr_ovr  (clr_ovr),
    .latch    (latch),
    .pending  (pending),
    .overrun  (overrun)
  );

  clkref_host_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .count      (count),
    .latch      (latch),
    .pending    (pending),
    .overrun    (overrun),
    .host_rdata (host_rdata),
    .irq        (irq),
    .load_en    (load_en),
    .load_sel   (load_sel),
    .load_data  (load_data),
    .stop_req   (stop_req),
    .resume_req (resume_req),
    .clr_pend   (clr_pend),
    .clr_ovr    (clr_ovr)
  );

  // R1
  run_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> running);

endmodule

// File: tb/clkref_capture_counter_test.sv
`timescale 1ns/1ps
module clkref_capture_counter_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {preset[41:0], wait cycles[5:0], expected live count[41:0]}
  localparam logic [89:0] VEC [NVEC] = '{
    {42'h000_0000_0000, 6'd1, 42'h000_0000_0001},
    {42'h003_1234_FFFE, 6'd1, 42'h003_1234_FFFF},
    {42'h000_0000_FFFF, 6'd2, 42'h000_0001_0001},
    {42'h3FF_FFFF_FFFF, 6'd1, 42'h000_0000_0000},
    {42'h0FF_FFFF_FFFE, 6'd3, 42'h100_0000_0001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_stb = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] d, a, b;
  logic [41:0] pre, expv;
  int k;

  clkref_capture_counter uut (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .host_wr(host_wr),
    .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] ad, input logic [15:0] wd);
    @(negedge clk);
    host_wr = 1'b1; host_addr = ad; host_wdata = wd;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] ad, output logic [15:0] rd);
    @(negedge clk);
    host_rd = 1'b1; host_addr = ad;
    #1 rd = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic pulse_cap();
    @(negedge clk);
    cap_stb = 1'b1;
    @(negedge clk);
    cap_stb = 1'b0;
  endtask

  task automatic preset(input logic [41:0] v);
    write_reg(3'd2, {6'b0, v[41:32]});
    write_reg(3'd1, v[31:16]);
    write_reg(3'd0, v[15:0]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    read_reg(3'd4, d); check("R10 ctrl", d, 16'h0000);
    read_reg(3'd5, d); check("R10 status", d, 16'h0000);
    check("R10 irq", {15'b0, irq}, 16'h0000);
    read_reg(3'd0, d); check("R10 latch lo", d, 16'h0000);
    read_reg(3'd2, d); check("R10 latch hi", d, 16'h0000);

    // R1 counting from reset without resume: reads 8 cycles apart
    write_reg(3'd4, 16'h8000);
    read_reg(3'd0, a);
    read_reg(3'd1, d);
    read_reg(3'd2, d);
    write_reg(3'd4, 16'h8000);
    read_reg(3'd0, b);
    read_reg(3'd1, d);
    read_reg(3'd2, d);
    check("R1 free-run step", b - a, 16'd8);

    // Vector table: R1 wrap, R3 map, R5 resume, R7 live snapshot and self-clear
    for (int i = 0; i < NVEC; i++) begin
      pre  = VEC[i][89:48];
      k    = int'(VEC[i][47:42]);
      expv = VEC[i][41:0];
      preset(pre);
      write_reg(3'd4, 16'h8000);
      write_reg(3'd3, 16'h0000);
      repeat (k) @(posedge clk);
      read_reg(3'd0, d); check("R5 R1 live lo", d, expv[15:0]);
      read_reg(3'd1, d); check("R7 R3 snapshot mid", d, expv[31:16]);
      read_reg(3'd2, d); check("R7 R3 snapshot hi", d, {6'b0, expv[41:32]});
      read_reg(3'd4, d); check("R7 select self-clear", d, 16'h0000);
    end

    // R4 low-word write keeps the count running
    preset(42'h0);
    write_reg(3'd4, 16'h8000);
    write_reg(3'd3, 16'h0000);
    write_reg(3'd0, 16'h0100);
    repeat (3) @(posedge clk);
    read_reg(3'd0, d); check("R4 lo load keeps running", d, 16'h0103);
    read_reg(3'd1, d); check("R4 mid unchanged", d, 16'h0000);
    read_reg(3'd2, d);

    // R4 middle-word write stops the count
    write_reg(3'd1, 16'h0055);
    write_reg(3'd4, 16'h8000);
    read_reg(3'd0, a);
    read_reg(3'd1, d); check("R4 mid load", d, 16'h0055);
    read_reg(3'd2, d);
    write_reg(3'd4, 16'h8000);
    read_reg(3'd0, b);
    read_reg(3'd2, d);
    check("R4 mid write stops", b, a);

    // R2 / R6 capture and latched read
    preset(42'h001_2222_3333);
    pulse_cap();
    read_reg(3'd0, d); check("R2 latch lo", d, 16'h3333);
    read_reg(3'd1, d); check("R2 latch mid", d, 16'h2222);
    read_reg(3'd2, d); check("R2 latch hi", d, 16'h0001);
    write_reg(3'd0, 16'h9999);
    read_reg(3'd0, d); check("R6 select 0 returns latch", d, 16'h3333);

    // R8 pending and mask
    read_reg(3'd5, d); check("R8 pending set", d, 16'h0001);
    check("R8 masked irq", {15'b0, irq}, 16'h0000);
    write_reg(3'd4, 16'h0001);
    check("R8 irq enabled", {15'b0, irq}, 16'h0001);

    // R9 overrun and latch overwrite
    pulse_cap();
    read_reg(3'd5, d); check("R9 overrun", d, 16'h0003);
    read_reg(3'd0, d); check("R9 latch overwritten", d, 16'h9999);
    write_reg(3'd5, 16'h0001);
    read_reg(3'd5, d); check("R8 pending clear", d, 16'h0002);
    check("R8 irq clear", {15'b0, irq}, 16'h0000);
    write_reg(3'd5, 16'h0002);
    read_reg(3'd5, d); check("R9 overrun clear", d, 16'h0000);

    // R8 capture wins over same-cycle clear
    pulse_cap();
    @(negedge clk);
    cap_stb = 1'b1; host_wr = 1'b1; host_addr = 3'd5; host_wdata = 16'h0001;
    @(negedge clk);
    cap_stb = 1'b0; host_wr = 1'b0;
    read_reg(3'd5, d); check("R8 capture beats clear", d, 16'h0003);
    check("R8 irq stays", {15'b0, irq}, 16'h0001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule